// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block lets a processor on the same chip read, byte-program and page-erase an embedded flash array through five small registers. Software writes an operation code to a mode register, an address to a high/low register pair and, for programming, a byte to a data register. It then writes a two-byte unlock pattern to a command register. Only an exact unlock pattern starts the selected operation, so a stray write cannot change the flash.

While an operation runs, a busy flag is raised and every register write is rejected. A read leaves the addressed byte in the data register. A program can only clear bits, so the stored byte becomes the old value ANDed with the new one. An erase returns a whole 512-byte page to all ones. The array is a behavioural model of a few pages held inside the block. Erase sweeps the page one byte per cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Register select codes are 0 mode, 1 address high, 2 address low, 3 data, 4 command. Reading the mode register returns the mode in bits [2:0] and the busy flag in bit 7. The command register reads as 0x00.
- R2: An operation starts only when the command register receives 0xB9 as the command write that directly follows a command write of 0x46. Writes to other registers in between do not break the pair.
- R3: Any other command write clears a pending first step. A 0x46 written at any point arms the first step again, so 0x46, 0x46, 0xB9 starts an operation.
- R4: The flash byte address is the high register (its low 3 bits) joined above the low register. Both registers read back what was written.
- R5: Mode 3'b010 programs the addressed byte with old AND data. Bits can only go from 1 to 0.
- R6: Mode 3'b011 sets all 512 bytes of one page to 0xFF and leaves the other pages unchanged.
- R7: For erase, the lower 9 address bits are ignored. A non-aligned address erases the page that contains it.
- R8: Mode 3'b001 places the addressed flash byte in the data register by the time busy falls.
- R9: Busy rises on the clock edge that accepts the starting command write. It stays high for 4 cycles for read or program, and for 512 cycles for erase.
- R10: While busy is high, every register write is ignored, including command writes and a data write in the last busy cycle.
- R11: A trigger with any other mode value raises no busy and leaves the flash unchanged.
- R12: After reset, all registers read 0x00, busy is low and no unlock step is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| busy | output | 1 | Operation in progress |

## Verification
A read operation loads its result into the data register on the same clock edge where a bus write to that register can arrive. The bench provokes this collision directly. It starts a read, counts busy cycles and drives a data-register write so that it is sampled on the final busy edge. It then judges the outcome by reading the data register back: it must hold the flash byte, not the bus value. A write one cycle later must then be accepted.

// File: rtl/flash_cmd_pkg.sv
// Shared constants and types for the flash command controller.
// Assumes: eight-bit register bus, three-bit register select.
package flash_cmd_pkg;

    localparam logic [2:0] REG_MODE    = 3'd0;
    localparam logic [2:0] REG_ADDR_HI = 3'd1;
    localparam logic [2:0] REG_ADDR_LO = 3'd2;
    localparam logic [2:0] REG_DATA    = 3'd3;
    localparam logic [2:0] REG_CMD     = 3'd4;

    localparam logic [2:0] MODE_READ  = 3'b001;
    localparam logic [2:0] MODE_PROG  = 3'b010;
    localparam logic [2:0] MODE_ERASE = 3'b011;

    localparam logic [7:0] UNLOCK_FIRST  = 8'h46;
    localparam logic [7:0] UNLOCK_SECOND = 8'hB9;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } op_t;

    // Map a mode field onto an operation; unknown codes give OP_IDLE.
    function automatic op_t decode_mode(logic [2:0] m);
        case (m)
            MODE_READ:  return OP_READ;
            MODE_PROG:  return OP_PROG;
            MODE_ERASE: return OP_ERASE;
            default:    return OP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/flash_unlock_detect.sv
// Two-step unlock detector for the command register.
// Fires for one cycle when the second key follows the first key
// on consecutive accepted command writes. Assumes cmd_wr is already
// gated by the busy flag.
module flash_unlock_detect
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_data,
    output logic       fire
);

    logic armed_q;

    // Second key seen while armed starts an operation.
    assign fire = cmd_wr && armed_q && (cmd_data == UNLOCK_SECOND);

    // Arm on the first key, disarm on any other command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (cmd_wr) begin
            armed_q <= (cmd_data == UNLOCK_FIRST);
        end
    end

endmodule

// File: rtl/flash_op_sequencer.sv
// Operation sequencer: latches the operation on a start pulse,
// holds busy for a fixed latency (read/program) or one cycle per
// byte of a page (erase), and drives the array port.
// Assumes the array has an asynchronous read and a synchronous write.
module flash_op_sequencer
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int PAGE_AW = 9,
    parameter int OP_LAT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata_in,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              rd_done,
    output logic [7:0]        rd_value
);

    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int LAT_W      = (OP_LAT > 1) ? $clog2(OP_LAT) : 1;
    localparam int CNT_W      = (PAGE_AW > LAT_W) ? PAGE_AW : LAT_W;

    op_t               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last;
    op_t               start_op;

    assign start_op = decode_mode(mode);
    assign busy     = (op_q != OP_IDLE);

    // Final busy cycle depends on the kind of operation.
    assign last = (op_q == OP_ERASE) ? (cnt_q == CNT_W'(PAGE_BYTES - 1))
                                     : (cnt_q == CNT_W'(OP_LAT - 1));

    // Latch an operation when idle; count busy cycles until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
            data_q <= '0;
            cnt_q  <= '0;
        end else if (op_q == OP_IDLE) begin
            if (start && start_op != OP_IDLE) begin
                op_q   <= start_op;
                addr_q <= addr;
                data_q <= wdata_in;
                cnt_q  <= '0;
            end
        end else if (last) begin
            op_q  <= OP_IDLE;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Erase walks the page by the counter; other operations use the latched address.
    always_comb begin
        if (op_q == OP_ERASE) begin
            mem_addr = {addr_q[ADDR_W-1:PAGE_AW], cnt_q[PAGE_AW-1:0]};
        end else begin
            mem_addr = addr_q;
        end
    end

    // Array write enable and write data per operation.
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = mem_rdata & data_q;
        if (op_q == OP_ERASE) begin
            mem_we    = 1'b1;
            mem_wdata = 8'hFF;
        end else if (op_q == OP_PROG && last) begin
            mem_we = 1'b1;
        end
    end

    assign rd_done  = (op_q == OP_READ) && last;
    assign rd_value = mem_rdata;

endmodule

// File: rtl/flash_array.sv
// Behavioural flash storage: asynchronous read, synchronous write.
// Content is not reset; software erases before use.
module flash_array #(
    parameter int ADDR_W = 11,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic [7:0] cells [DEPTH];

    // Store one byte when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Flash command controller top: register file, unlock detector,
// operation sequencer and array. Register writes are accepted only
// while idle. Assumes PAGE_AW >= 8 and an address of 9 to 16 bits.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int PAGE_COUNT = 4,
    parameter int PAGE_AW    = 9,
    parameter int OP_LAT     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_sel,
    output logic [7:0] rd_data,
    output logic       busy
);

    localparam int PAGE_BITS = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 0;
    localparam int ADDR_W    = PAGE_AW + PAGE_BITS;
    localparam int HI_W      = ADDR_W - 8;
    localparam int DEPTH     = PAGE_COUNT << PAGE_AW;

    logic [2:0]        mode_q;
    logic [HI_W-1:0]   hi_q;
    logic [7:0]        lo_q;
    logic [7:0]        data_q;
    logic              wr_ok;
    logic              fire;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;
    logic              rd_done;
    logic [7:0]        rd_value;

    assign wr_ok = wr_en && !busy;

    // Mode and address registers take bus writes while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else if (wr_ok) begin
            case (wr_sel)
                REG_MODE:    mode_q <= wr_data[2:0];
                REG_ADDR_HI: hi_q   <= wr_data[HI_W-1:0];
                REG_ADDR_LO: lo_q   <= wr_data;
                default:     ;
            endcase
        end
    end

    // Data register: read result wins, bus write only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_done) begin
            data_q <= rd_value;
        end else if (wr_ok && wr_sel == REG_DATA) begin
            data_q <= wr_data;
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (rd_sel)
            REG_MODE:    rd_data = {busy, 4'b0000, mode_q};
            REG_ADDR_HI: rd_data = 8'(hi_q);
            REG_ADDR_LO: rd_data = lo_q;
            REG_DATA:    rd_data = data_q;
            default:     rd_data = 8'h00;
        endcase
    end

    flash_unlock_detect u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_ok && (wr_sel == REG_CMD)),
        .cmd_data (wr_data),
        .fire     (fire)
    );

    flash_op_sequencer #(
        .ADDR_W  (ADDR_W),
        .PAGE_AW (PAGE_AW),
        .OP_LAT  (OP_LAT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fire),
        .mode      (mode_q),
        .addr      ({hi_q, lo_q}),
        .wdata_in  (data_q),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rd_done   (rd_done),
        .rd_value  (rd_value)
    );

    flash_array #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/flash_cmd_chk.sv
// Assertion checker for flash_cmd_ctrl, attached by bind.
module flash_cmd_chk
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int PAGE_AW = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [7:0]        wr_data,
    input logic              busy,
    input logic [2:0]        mode_q,
    input logic [ADDR_W-9:0] hi_q,
    input logic [7:0]        lo_q,
    input logic [7:0]        data_q,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata
);

    assert_start_after_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && wr_sel == REG_CMD && wr_data == UNLOCK_SECOND));

    assert_known_mode_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mode_q == MODE_READ || mode_q == MODE_PROG || mode_q == MODE_ERASE));

    assert_regs_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(mode_q) && $stable(hi_q) && $stable(lo_q)));

    assert_write_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_erase_in_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_q == MODE_ERASE) |->
            (mem_addr[ADDR_W-1:PAGE_AW] == hi_q[ADDR_W-9:PAGE_AW-8] && mem_wdata == 8'hFF));

    assert_prog_clears_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_q == MODE_PROG) |->
            ((mem_wdata & ~data_q) == 8'h00 && mem_addr == {hi_q, lo_q}));

    assert_reset_idle_R12: assert property (@(posedge clk)
        !rst_n |=> !busy);

endmodule

bind flash_cmd_ctrl flash_cmd_chk #(
    .ADDR_W  (ADDR_W),
    .PAGE_AW (PAGE_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .busy      (busy),
    .mode_q    (mode_q),
    .hi_q      (hi_q),
    .lo_q      (lo_q),
    .data_q    (data_q),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/sim_flash_cmd_ctrl.sv
// Directed bench for flash_cmd_ctrl: one task per scenario.
module sim_flash_cmd_ctrl;

    localparam int PAGES  = 4;
    localparam int PBYTES = 512;
    localparam int LAT    = 4;
    localparam int DEPTH  = PAGES * PBYTES;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_sel = 3'd0;
    logic [7:0] rd_data;
    logic       busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] model [DEPTH];

    flash_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] sel, output logic [7:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy === 1'b1) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic start_op(input logic [2:0] m, input logic [10:0] a, input logic [7:0] d);
        bus_write(3'd0, {5'b0, m});
        bus_write(3'd1, {5'b0, a[10:8]});
        bus_write(3'd2, a[7:0]);
        bus_write(3'd3, d);
        bus_write(3'd4, 8'h46);
        bus_write(3'd4, 8'hB9);
    endtask

    task automatic flash_read(input logic [10:0] a, output logic [7:0] v);
        int n;
        start_op(3'b001, a, 8'h00);
        wait_idle(n);
        bus_read(3'd3, v);
    endtask

    task automatic model_erase(input logic [10:0] a);
        for (int i = 0; i < PBYTES; i++) model[{a[10:9], 9'(i)}] = 8'hFF;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int s = 0; s < 5; s++) begin
            bus_read(3'(s), v);
            check($sformatf("R12 reg %0d after reset", s), v, 8'h00);
        end
        check("R12 busy after reset", busy, 1'b0);
        bus_write(3'd4, 8'hB9);
        check("R12 no pending step after reset", busy, 1'b0);
    endtask

    task automatic t_erase_all();
        int n;
        logic [7:0] v;
        for (int p = 0; p < PAGES; p++) begin
            start_op(3'b011, 11'(p * PBYTES), 8'h00);
            bus_read(3'd0, v);
            check("R1 busy bit in mode register", v, 8'h83);
            wait_idle(n);
            check("R9 erase busy length", n, PBYTES);
            model_erase(11'(p * PBYTES));
        end
        flash_read(11'h000, v); check("R6 erased first byte", v, 8'hFF);
        flash_read(11'h7FF, v); check("R6 erased last byte", v, 8'hFF);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        bus_write(3'd1, 8'hFD);
        bus_read(3'd1, v); check("R4 high register keeps low 3 bits", v, 8'h05);
        bus_write(3'd2, 8'h9C);
        bus_read(3'd2, v); check("R4 low register readback", v, 8'h9C);
        bus_write(3'd0, 8'h02);
        bus_read(3'd0, v); check("R1 mode readback", v, 8'h02);
        bus_read(3'd4, v); check("R1 command reads zero", v, 8'h00);
    endtask

    task automatic t_program();
        int n;
        logic [7:0] v;
        start_op(3'b010, 11'h123, 8'hA5);
        wait_idle(n);
        check("R9 program busy length", n, LAT);
        model[11'h123] = model[11'h123] & 8'hA5;
        flash_read(11'h123, v); check("R5 first program", v, model[11'h123]);
        start_op(3'b010, 11'h123, 8'h3C);
        wait_idle(n);
        model[11'h123] = model[11'h123] & 8'h3C;
        flash_read(11'h123, v); check("R5 second program ANDs", v, 8'h24);
        start_op(3'b010, 11'h5B7, 8'h81);
        wait_idle(n);
        model[11'h5B7] = 8'h81;
        flash_read(11'h5B7, v); check("R4 joined address high/low", v, model[11'h5B7]);
    endtask

    task automatic t_misaligned_erase();
        int n;
        logic [7:0] v;
        start_op(3'b010, 11'h3FF, 8'h11); wait_idle(n); model[11'h3FF] = 8'h11;
        start_op(3'b010, 11'h400, 8'h22); wait_idle(n); model[11'h400] = 8'h22;
        start_op(3'b010, 11'h5FF, 8'h33); wait_idle(n); model[11'h5FF] = 8'h33;
        start_op(3'b011, 11'h4FF, 8'h00); wait_idle(n);
        model_erase(11'h4FF);
        flash_read(11'h400, v); check("R7 page start erased", v, 8'hFF);
        flash_read(11'h5FF, v); check("R7 page end erased", v, 8'hFF);
        flash_read(11'h3FF, v); check("R6 neighbour page kept", v, model[11'h3FF]);
        flash_read(11'h5B7, v); check("R6 erased byte in page", v, 8'hFF);
    endtask

    task automatic t_sequence();
        int n;
        logic [7:0] v;
        bus_write(3'd0, 8'h01);
        bus_write(3'd4, 8'h46); bus_write(3'd4, 8'h00); bus_write(3'd4, 8'hB9);
        check("R3 wrong byte breaks sequence", busy, 1'b0);
        bus_write(3'd4, 8'hB9);
        check("R2 second key alone", busy, 1'b0);
        bus_write(3'd4, 8'h46); bus_write(3'd4, 8'h46); bus_write(3'd4, 8'hB9);
        check("R3 repeated first key restarts", busy, 1'b1);
        wait_idle(n);
        bus_write(3'd1, 8'h01); bus_write(3'd2, 8'h23);
        bus_write(3'd4, 8'h46); bus_write(3'd2, 8'h23); bus_write(3'd4, 8'hB9);
        check("R2 other register write between keys", busy, 1'b1);
        wait_idle(n);
        bus_read(3'd3, v); check("R8 read result in data register", v, model[11'h123]);
    endtask

    task automatic t_bad_mode();
        int n;
        logic [7:0] v;
        start_op(3'b111, 11'h200, 8'h00);
        check("R11 unknown mode no busy", busy, 1'b0);
        start_op(3'b000, 11'h201, 8'h00);
        check("R11 zero mode no busy", busy, 1'b0);
        flash_read(11'h200, v); check("R11 flash unchanged", v, model[11'h200]);
        flash_read(11'h201, v); check("R11 flash unchanged 2", v, model[11'h201]);
        n = 0;
    endtask

    task automatic t_busy_ignore();
        int n;
        logic [7:0] v;
        start_op(3'b011, 11'h600, 8'h00);
        bus_write(3'd2, 8'h55);
        bus_write(3'd0, 8'h01);
        bus_write(3'd4, 8'h46);
        wait_idle(n);
        model_erase(11'h600);
        bus_read(3'd2, v); check("R10 low register frozen", v, 8'h00);
        bus_read(3'd0, v); check("R10 mode register frozen", v, 8'h03);
        bus_write(3'd4, 8'hB9);
        check("R10 command write while busy ignored", busy, 1'b0);
        start_op(3'b010, 11'h123, 8'hFF); wait_idle(n);
        start_op(3'b001, 11'h123, 8'h00);
        repeat (LAT - 1) @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd3; wr_data = 8'hEE;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 busy falls after read", busy, 1'b0);
        bus_read(3'd3, v); check("R10 last busy cycle write loses to read", v, model[11'h123]);
        bus_write(3'd3, 8'h5A);
        bus_read(3'd3, v); check("R10 write accepted once idle", v, 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_erase_all();
        t_regs();
        t_program();
        t_misaligned_erase();
        t_sequence();
        t_bad_mode();
        t_busy_ignore();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule